// File: doc/BRIEF.md
# Flash Command Post-Delay Sequencer

This block sits next to a serial flash command engine and covers two jobs that follow a command: it inserts a programmable idle period after some power-management and suspend/resume commands, and it keeps a flag that shows whether a program or erase operation in the flash is currently suspended. The engine reports each finished command with a one-cycle done pulse and a 3-bit type code. The block then holds a `busy` output high for the required number of SPI clock cycles, and the engine must not start the next transaction while `busy` is high.

The wait length is a 10-bit base value multiplied by 4 or by 256. Each command type has its own select bit that chooses the multiplier. The waits after suspend and after resume each have their own enable. The block samples all of these settings at the done pulse, so changes made while a wait is running do not affect it. Serial shifting, chip-select timing and register access belong to other blocks.

Top module: `flash_post_delay`

## Requirements
- R1: Command codes are 0 = deep power-down, 1 = high-performance mode, 2 = release from power-down, 3 = suspend, 4 = resume. When a done pulse with code 0, 1 or 2 is accepted, `busy` is high for exactly `base_delay × M` consecutive cycles, starting in the cycle after the pulse.
- R2: `scale_sel[i]` selects the multiplier for code i: M = 256 when the bit is 1 and M = 4 when it is 0. Each bit applies only to its own code.
- R3: A suspend command (code 3) produces a wait only when `sus_wait_en` is 1. When it is 0, `busy` stays low.
- R4: A resume command (code 4) produces a wait only when `res_wait_en` is 1. When it is 0, `busy` stays low.
- R5: `suspended` goes to 1 in the cycle after a done pulse with code 3.
- R6: `suspended` goes to 0 in the cycle after a done pulse with code 4.
- R7: The base delay, the scale bits and the enables are captured at the done pulse. Changing them while a wait is running does not change its length.
- R8: A base delay of 0 gives no wait, and `suspended` still updates.
- R9: A done pulse that arrives while `busy` is high does not start or change a wait, but it still updates `suspended`.
- R10: Codes 5 to 7 cause no wait and leave `suspended` unchanged.
- R11: A synchronous active-low reset clears `busy` and `suspended`. The internal counter is wide enough for the longest wait, 1023 × 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SPI clock; one count per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_done | input | 1 | One-cycle pulse: a command has finished |
| cmd_code | input | 3 | Type of the finished command (see R1) |
| base_delay | input | 10 | Shared base wait value |
| scale_sel | input | 5 | Multiplier select for each command type, 1 = ×256, 0 = ×4 |
| sus_wait_en | input | 1 | Enables the wait after a suspend |
| res_wait_en | input | 1 | Enables the wait after a resume |
| busy | output | 1 | Holds off the next transaction |
| suspended | output | 1 | Flash suspend status |

## Verification
The assertions assume that `cmd_done` is a clean pulse and that every input is known in each cycle after reset. They also assume that the same pulse never asks for both a suspend and a resume, which the 3-bit code makes impossible. The stimulus changes inputs only on falling edges, drops `cmd_done` after one cycle, and keeps base values in 10 bits. Waits are measured by counting the cycles in which `busy` is high. Wait lengths stay well under the run limit: the longest wait used is a ×256 wait of 76,800 cycles, which exercises the upper counter bits without reaching the full maximum.

// File: rtl/flash_pdly_pkg.sv
// Package: shared constants and the command-type encoding for the
// post-delay sequencer. Assumes code values are fixed by the engine.
package flash_pdly_pkg;

    localparam int CODE_W   = 3;
    localparam int NUM_CMDS = 5;

    typedef enum logic [CODE_W-1:0] {
        CMD_DPD   = 3'd0,
        CMD_HPM   = 3'd1,
        CMD_REL   = 3'd2,
        CMD_SUS   = 3'd3,
        CMD_RSM   = 3'd4
    } flash_cmd_e;

    // Result of decoding one done pulse
    typedef struct packed {
        logic wait_req;   // command type asks for a post-delay
        logic scale_hi;   // chosen multiplier is the large one
        logic set_sus;    // raise suspend flag
        logic clr_sus;    // drop suspend flag
    } cmd_dec_t;

endpackage

// File: rtl/pdly_cmd_decode.sv
// Module: pdly_cmd_decode
// Turns the command code plus its per-type scale and enable bits into a
// wait request and suspend-flag actions. Purely combinational.
// Assumes codes at or above NUM_CMDS are "no action".
module pdly_cmd_decode
    import flash_pdly_pkg::*;
#(
    parameter int N_CMDS = NUM_CMDS
) (
    input  logic              cmd_done,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [N_CMDS-1:0] scale_sel,
    input  logic              sus_wait_en,
    input  logic              res_wait_en,
    output cmd_dec_t          dec
);

    logic known;
    logic scale_pick;

    // Select the scale bit belonging to the current code
    always_comb begin
        known      = 1'b0;
        scale_pick = 1'b0;
        for (int i = 0; i < N_CMDS; i++) begin
            if (cmd_code == i[CODE_W-1:0]) begin
                known      = 1'b1;
                scale_pick = scale_sel[i];
            end
        end
    end

    // Build wait request and flag actions from the code
    always_comb begin
        dec          = '0;
        dec.scale_hi = scale_pick;
        if (cmd_done && known) begin
            unique case (cmd_code)
                CMD_SUS: begin
                    dec.wait_req = sus_wait_en;
                    dec.set_sus  = 1'b1;
                end
                CMD_RSM: begin
                    dec.wait_req = res_wait_en;
                    dec.clr_sus  = 1'b1;
                end
                default: dec.wait_req = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pdly_target_calc.sv
// Module: pdly_target_calc
// Scales the shared base value by 2**SHIFT_LO or 2**SHIFT_HI. Both shifts
// are constant, so this is wiring plus one 2:1 mux.
// Assumes CNT_W >= BASE_W + SHIFT_HI.
module pdly_target_calc #(
    parameter int BASE_W   = 10,
    parameter int SHIFT_LO = 2,
    parameter int SHIFT_HI = 8,
    parameter int CNT_W    = BASE_W + SHIFT_HI
) (
    input  logic [BASE_W-1:0] base,
    input  logic              scale_hi,
    output logic [CNT_W-1:0]  target,
    output logic              is_zero
);

    logic [CNT_W-1:0] base_ext;

    // Widen base before shifting so no bits are lost
    always_comb base_ext = CNT_W'(base);

    // Pick the scaled value
    always_comb target = scale_hi ? (base_ext << SHIFT_HI) : (base_ext << SHIFT_LO);

    // Zero base gives zero wait regardless of scale
    always_comb is_zero = (base == '0);

endmodule

// File: rtl/pdly_wait_counter.sv
// Module: pdly_wait_counter
// Captures a target on start and holds busy for exactly that many cycles.
// Assumes start is only honoured while idle and target is nonzero.
module pdly_wait_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] target,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic             last;

    // Final busy cycle when the count meets the captured target
    always_comb last = busy && (cnt_q == tgt_q);

    // Run the counter and the busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= CNT_W'(1);
                tgt_q <= target;
            end
        end else if (last) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pdly_sus_flag.sv
// Module: pdly_sus_flag
// Holds the suspend status. Set and clear never arrive together.
module pdly_sus_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);

    // Update status on suspend or resume
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end

endmodule

// File: rtl/flash_post_delay.sv
// Module: flash_post_delay (top)
// Counts a programmable wait after selected flash commands and tracks the
// suspend status. Assumes cmd_done is a single-cycle pulse in the clk domain.
module flash_post_delay
    import flash_pdly_pkg::*;
#(
    parameter int BASE_W   = 10,
    parameter int SHIFT_LO = 2,
    parameter int SHIFT_HI = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic [2:0]        cmd_code,
    input  logic [BASE_W-1:0] base_delay,
    input  logic [4:0]        scale_sel,
    input  logic              sus_wait_en,
    input  logic              res_wait_en,
    output logic              busy,
    output logic              suspended
);

    localparam int CNT_W = BASE_W + SHIFT_HI;

    cmd_dec_t         dec;
    logic [CNT_W-1:0] target;
    logic             base_zero;
    logic             start;

    pdly_cmd_decode #(.N_CMDS(NUM_CMDS)) u_dec (
        .cmd_done    (cmd_done),
        .cmd_code    (cmd_code),
        .scale_sel   (scale_sel),
        .sus_wait_en (sus_wait_en),
        .res_wait_en (res_wait_en),
        .dec         (dec)
    );

    pdly_target_calc #(
        .BASE_W   (BASE_W),
        .SHIFT_LO (SHIFT_LO),
        .SHIFT_HI (SHIFT_HI),
        .CNT_W    (CNT_W)
    ) u_tgt (
        .base     (base_delay),
        .scale_hi (dec.scale_hi),
        .target   (target),
        .is_zero  (base_zero)
    );

    // Start a wait only for a nonzero request; busy gating is in the counter
    always_comb start = dec.wait_req && !base_zero;

    pdly_wait_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .target (target),
        .busy   (busy)
    );

    pdly_sus_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dec.set_sus),
        .clr_i (dec.clr_sus),
        .flag  (suspended)
    );

endmodule

// File: rtl/flash_post_delay_chk.sv
// Checker for flash_post_delay, attached by bind below.
module flash_post_delay_chk #(
    parameter int BASE_W   = 10,
    parameter int SHIFT_HI = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_done,
    input logic [2:0]        cmd_code,
    input logic [BASE_W-1:0] base_delay,
    input logic              sus_wait_en,
    input logic              res_wait_en,
    input logic              busy,
    input logic              suspended
);

    localparam int RUN_W = BASE_W + SHIFT_HI + 1;
    localparam logic [RUN_W-1:0] MAX_RUN = RUN_W'(((1 << BASE_W) - 1) << SHIFT_HI);

    logic [RUN_W-1:0] run_len;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + RUN_W'(1);
        else           run_len <= '0;
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!busy && !suspended));

    // R1
    busy_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_done));

    // R1
    power_cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !busy && cmd_code <= 3'd2 && base_delay != '0) |=> busy);

    // R3
    sus_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !busy && cmd_code == 3'd3 && !sus_wait_en) |=> !busy);

    // R4
    rsm_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !busy && cmd_code == 3'd4 && !res_wait_en) |=> !busy);

    // R5
    sus_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_code == 3'd3) |=> suspended);

    // R6
    sus_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_code == 3'd4) |=> !suspended);

    // R8
    zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !busy && base_delay == '0) |=> !busy);

    // R10
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(suspended)) |-> $past(cmd_done && (cmd_code == 3'd3 || cmd_code == 3'd4)));

    // R11
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= MAX_RUN);

endmodule

bind flash_post_delay flash_post_delay_chk #(
    .BASE_W   (BASE_W),
    .SHIFT_HI (SHIFT_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_done    (cmd_done),
    .cmd_code    (cmd_code),
    .base_delay  (base_delay),
    .sus_wait_en (sus_wait_en),
    .res_wait_en (res_wait_en),
    .busy        (busy),
    .suspended   (suspended)
);

// File: tb/tb_flash_post_delay.sv
module tb_flash_post_delay;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_done = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [9:0] base_delay = 10'd0;
    logic [4:0] scale_sel = 5'd0;
    logic       sus_wait_en = 1'b0;
    logic       res_wait_en = 1'b0;
    logic       busy;
    logic       suspended;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_all = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    flash_post_delay dut (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_code(cmd_code),
        .base_delay(base_delay), .scale_sel(scale_sel),
        .sus_wait_en(sus_wait_en), .res_wait_en(res_wait_en),
        .busy(busy), .suspended(suspended)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One done pulse; returns at the falling edge after it
    task automatic pulse(input logic [2:0] code);
        @(negedge clk);
        cmd_code = code;
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    // Count cycles with busy high from now on
    task automatic measure(output int n);
        n = 0;
        while (busy && n < 300000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [2:0] code, output int n);
        pulse(code);
        measure(n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 busy after reset", busy, 0);
        check("R11 suspended after reset", suspended, 0);
    endtask

    task automatic t_power_cmds();
        int n;
        base_delay = 10'd3; scale_sel = 5'b00000;
        run_cmd(3'd0, n); check("R1 deep power-down x4", n, 12);
        base_delay = 10'd2; scale_sel = 5'b00010;
        run_cmd(3'd1, n); check("R2 high-perf x256", n, 512);
        base_delay = 10'd5; scale_sel = 5'b11011;
        run_cmd(3'd2, n); check("R2 release own bit x4", n, 20);
        base_delay = 10'd1; scale_sel = 5'b11110;
        run_cmd(3'd0, n); check("R2 dpd own bit x4", n, 4);
    endtask

    task automatic t_suspend_resume();
        int n;
        base_delay = 10'd1; scale_sel = 5'b00000;
        sus_wait_en = 1'b1;
        run_cmd(3'd3, n); check("R3 suspend wait enabled", n, 4);
        check("R5 flag set", suspended, 1);
        res_wait_en = 1'b0;
        run_cmd(3'd4, n); check("R4 resume wait disabled", n, 0);
        check("R6 flag cleared", suspended, 0);
        sus_wait_en = 1'b0;
        run_cmd(3'd3, n); check("R3 suspend wait disabled", n, 0);
        check("R5 flag set no wait", suspended, 1);
        res_wait_en = 1'b1; scale_sel = 5'b10000;
        run_cmd(3'd4, n); check("R4 resume wait x256", n, 256);
        check("R6 flag cleared after wait", suspended, 0);
    endtask

    task automatic t_sampling();
        int n;
        base_delay = 10'd4; scale_sel = 5'b00000;
        pulse(3'd0);
        base_delay = 10'd9; scale_sel = 5'b11111;
        measure(n);
        check("R7 settings captured at pulse", n, 16);
    endtask

    task automatic t_zero();
        int n;
        base_delay = 10'd0; scale_sel = 5'b11111;
        sus_wait_en = 1'b1; res_wait_en = 1'b1;
        run_cmd(3'd3, n); check("R8 zero base no wait", n, 0);
        check("R8 flag still set", suspended, 1);
        run_cmd(3'd4, n); check("R8 zero base resume", n, 0);
        check("R8 flag still cleared", suspended, 0);
    endtask

    task automatic t_overlap();
        int n;
        base_delay = 10'd10; scale_sel = 5'b00000;
        sus_wait_en = 1'b1;
        pulse(3'd0);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (n == 5) begin cmd_code = 3'd3; base_delay = 10'd50; cmd_done = 1'b1; end
            else cmd_done = 1'b0;
            @(negedge clk);
        end
        cmd_done = 1'b0;
        check("R9 overlap keeps length", n, 40);
        check("R9 overlap flag set", suspended, 1);
        @(negedge clk);
        check("R9 no second wait", busy, 0);
    endtask

    task automatic t_unused_codes();
        int n;
        base_delay = 10'd7; scale_sel = 5'b11111;
        for (int c = 5; c < 8; c++) begin
            run_cmd(3'(c), n);
            check("R10 unused code no wait", n, 0);
            check("R10 unused code flag held", suspended, 1);
        end
    endtask

    task automatic t_long();
        int n;
        base_delay = 10'd300; scale_sel = 5'b00001;
        run_cmd(3'd0, n);
        check("R11 long wait x256", n, 76800);
    endtask

    task automatic t_reset_mid();
        base_delay = 10'd20; scale_sel = 5'b00000;
        pulse(3'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears busy", busy, 0);
        check("R11 reset clears flag", suspended, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_power_cmds();
        t_suspend_resume();
        t_sampling();
        t_zero();
        t_overlap();
        t_unused_codes();
        t_long();
        t_reset_mid();
        done_all = 1'b1;
    end

    initial begin
        fork
            wait (done_all);
            begin
                repeat (190000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule